// File: doc/BRIEF.md
# Packet-filter VM instruction decoder

This block takes a stream of 64-bit instruction words for a small packet-filter virtual machine and emits one decoded instruction per instruction. Each decoded instruction is split into the instruction class, the operand source selector, the operation code, the destination and source register numbers, a signed 16-bit offset and a 64-bit immediate. It also carries a flag that marks the instruction as a two-word wide load and a flag that marks a malformed encoding.

Most instructions are one word long. The wide load-immediate instruction (opcode 0x18) is followed by a second word that carries the upper half of a 64-bit constant. The decoder keeps the first word, waits for the second, and emits a single instruction whose immediate joins the two halves. It also checks that the reserved fields of the trailing word are zero. Words enter through a valid/ready handshake, and decoded instructions leave through a valid/ready handshake with one register stage.

Top module: `pfvm_insn_decoder`

## Requirements
- R1: While reset is held and after it is released, out_valid is 0, and in_ready is 1 while no instruction is pending.
- R2: Word fields are imm = bits 63:32, offset = bits 31:16, source register = bits 15:12, destination register = bits 11:8 and opcode = bits 7:0. The outputs are out_cls = opcode bits 2:0, out_srcsel = opcode bit 3 (1 selects the register, 0 selects the immediate) and out_op = opcode bits 7:4.
- R3: For any word whose opcode is not 0x18, one instruction is emitted in the cycle after the word is accepted. Its out_imm is the 32-bit imm sign-extended to 64 bits, and out_wide is 0.
- R4: A word with opcode 0x18 produces no output when it is accepted. After the next word is accepted, one instruction is emitted. It carries the fields of the first word, out_wide = 1 and out_imm = {second word bits 63:32, first word bits 63:32}.
- R5: out_err is 1 when the destination register field is greater than 10, or when the source register field of a single-word instruction is greater than 10. The source field of a wide load is not range-checked.
- R6: For a wide load, out_err is 1 when bits 31:0 of the second word (opcode, registers and offset) are not all zero.
- R7: While out_valid is 1 and out_ready is 0, all outputs hold their values and in_ready is 0, so no word is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Decoder can take a word |
| in_word | input | 64 | Instruction word |
| out_valid | output | 1 | Decoded instruction valid |
| out_ready | input | 1 | Consumer takes the instruction |
| out_cls | output | 3 | Instruction class |
| out_srcsel | output | 1 | 1: register source, 0: immediate source |
| out_op | output | 4 | Operation code |
| out_dst | output | 4 | Destination register number |
| out_src | output | 4 | Source register number |
| out_off | output | 16 | Signed offset |
| out_imm | output | 64 | Immediate (sign-extended or joined) |
| out_wide | output | 1 | Instruction came from two words |
| out_err | output | 1 | Malformed encoding |

## Verification
Single-word vectors with negative, large positive and zero immediates separate sign extension from zero extension, and they confirm that each field is taken from the right bits. Wide-load vectors use a low half that has its top bit set and a high half with only bit 63 set. This tells a correct concatenation apart from a sign-extended or swapped one. Other wide-load vectors put nonzero offset or opcode bits in the trailing word to show that the reserved-field check is present. Register numbers 10, 11 and 12 are placed at the edge of the range, and a wide load with a nonzero source field shows that this field is left unchecked. A stalled consumer shows that the outputs are held and that input is blocked while they are.

// File: rtl/pfvm_pkg.sv
package pfvm_pkg;
  localparam int WORD_W = 64;
  localparam int IMM_W  = 32;
  localparam int OFF_W  = 16;
  localparam int REG_W  = 4;
  localparam int OPC_W  = 8;
  localparam int CLS_W  = 3;
  localparam int OP_W   = 4;
  localparam int WIMM_W = 2 * IMM_W;

  // Word layout, most significant field first (position is behaviour).
  typedef struct packed {
    logic [IMM_W-1:0] imm;
    logic [OFF_W-1:0] off;
    logic [REG_W-1:0] src;
    logic [REG_W-1:0] dst;
    logic [OPC_W-1:0] opc;
  } word_t;

  typedef struct packed {
    logic [CLS_W-1:0]  cls;
    logic              srcsel;
    logic [OP_W-1:0]   op;
    logic [REG_W-1:0]  dst;
    logic [REG_W-1:0]  src;
    logic [OFF_W-1:0]  off;
    logic [WIMM_W-1:0] imm;
    logic              wide;
    logic              err;
  } insn_t;

  function automatic logic [WIMM_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
    return {{IMM_W{v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [WIMM_W-1:0] join_imm(input logic [IMM_W-1:0] lo,
                                                 input logic [IMM_W-1:0] hi);
    return {hi, lo};
  endfunction

  function automatic logic reg_bad(input logic [REG_W-1:0] r, input int unsigned max_reg);
    return int'(r) > int'(max_reg);
  endfunction

  function automatic logic pseudo_bad(input word_t w);
    return (w.off != '0) || (w.src != '0) || (w.dst != '0) || (w.opc != '0);
  endfunction
endpackage

// File: rtl/pfvm_field_split.sv
module pfvm_field_split
  import pfvm_pkg::*;
#(
  parameter int unsigned MAX_REG = 10
) (
  input  logic [WORD_W-1:0] word,
  output word_t             fields,
  output logic              dst_bad,
  output logic              src_bad,
  output logic              rsvd_bad
);
  always_comb begin
    fields   = word_t'(word);
    dst_bad  = reg_bad(fields.dst, MAX_REG);
    src_bad  = reg_bad(fields.src, MAX_REG);
    rsvd_bad = pseudo_bad(fields);
  end
endmodule

// File: rtl/pfvm_wide_joiner.sv
module pfvm_wide_joiner
  import pfvm_pkg::*;
#(
  parameter logic [OPC_W-1:0] WIDE_OPC = 8'h18
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  accept,
  input  word_t fields,
  input  logic  dst_bad,
  input  logic  src_bad,
  input  logic  rsvd_bad,
  output logic  emit,
  output insn_t insn,
  output logic  waiting
);
  logic  waiting_q;
  word_t held_q;
  logic  held_dst_bad_q;
  logic  first_is_wide;

  assign first_is_wide = (fields.opc == WIDE_OPC);
  assign waiting       = waiting_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting_q      <= 1'b0;
      held_q         <= '0;
      held_dst_bad_q <= 1'b0;
    end else if (accept) begin
      if (!waiting_q && first_is_wide) begin
        waiting_q      <= 1'b1;
        held_q         <= fields;
        held_dst_bad_q <= dst_bad;
      end else begin
        waiting_q <= 1'b0;
      end
    end
  end

  always_comb begin
    emit = accept && (waiting_q || !first_is_wide);
    if (waiting_q) begin
      insn.cls    = held_q.opc[CLS_W-1:0];
      insn.srcsel = held_q.opc[CLS_W];
      insn.op     = held_q.opc[OPC_W-1:OPC_W-OP_W];
      insn.dst    = held_q.dst;
      insn.src    = held_q.src;
      insn.off    = held_q.off;
      insn.imm    = join_imm(held_q.imm, fields.imm);
      insn.wide   = 1'b1;
      insn.err    = held_dst_bad_q || rsvd_bad;
    end else begin
      insn.cls    = fields.opc[CLS_W-1:0];
      insn.srcsel = fields.opc[CLS_W];
      insn.op     = fields.opc[OPC_W-1:OPC_W-OP_W];
      insn.dst    = fields.dst;
      insn.src    = fields.src;
      insn.off    = fields.off;
      insn.imm    = sext_imm(fields.imm);
      insn.wide   = 1'b0;
      insn.err    = dst_bad || src_bad;
    end
  end

  // R6
  pseudo_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting_q && accept && (fields.off != '0 || fields.opc != '0)) |-> (emit && insn.err));

  // R4
  wide_first_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!waiting_q && accept && fields.opc == WIDE_OPC) |=> waiting_q);
endmodule

// File: rtl/pfvm_out_stage.sv
module pfvm_out_stage
  import pfvm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  emit,
  input  insn_t insn_in,
  input  logic  out_ready,
  output logic  out_valid,
  output insn_t insn_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      insn_q    <= '0;
    end else begin
      if (emit) begin
        out_valid <= 1'b1;
        insn_q    <= insn_in;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(insn_q)));

  // R7
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> (!out_valid || out_ready));
endmodule

// File: rtl/pfvm_insn_decoder.sv
module pfvm_insn_decoder
  import pfvm_pkg::*;
#(
  parameter int unsigned      MAX_REG  = 10,
  parameter logic [OPC_W-1:0] WIDE_OPC = 8'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CLS_W-1:0]  out_cls,
  output logic              out_srcsel,
  output logic [OP_W-1:0]   out_op,
  output logic [REG_W-1:0]  out_dst,
  output logic [REG_W-1:0]  out_src,
  output logic [OFF_W-1:0]  out_off,
  output logic [WIMM_W-1:0] out_imm,
  output logic              out_wide,
  output logic              out_err
);
  word_t fields;
  logic  dst_bad, src_bad, rsvd_bad;
  logic  accept, emit, waiting;
  insn_t dec, held;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  pfvm_field_split #(.MAX_REG(MAX_REG)) u_split (
    .word(in_word), .fields(fields),
    .dst_bad(dst_bad), .src_bad(src_bad), .rsvd_bad(rsvd_bad)
  );

  pfvm_wide_joiner #(.WIDE_OPC(WIDE_OPC)) u_join (
    .clk(clk), .rst_n(rst_n), .accept(accept), .fields(fields),
    .dst_bad(dst_bad), .src_bad(src_bad), .rsvd_bad(rsvd_bad),
    .emit(emit), .insn(dec), .waiting(waiting)
  );

  pfvm_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .emit(emit), .insn_in(dec),
    .out_ready(out_ready), .out_valid(out_valid), .insn_q(held)
  );

  assign out_cls    = held.cls;
  assign out_srcsel = held.srcsel;
  assign out_op     = held.op;
  assign out_dst    = held.dst;
  assign out_src    = held.src;
  assign out_off    = held.off;
  assign out_imm    = held.imm;
  assign out_wide   = held.wide;
  assign out_err    = held.err;

  // R3
  sext_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_wide) |-> (out_imm[WIMM_W-1:IMM_W] == {IMM_W{out_imm[IMM_W-1]}}));

  // R5
  dst_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && int'(out_dst) > int'(MAX_REG)) |-> out_err);

  // R4
  wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !accept) |=> !emit || waiting || $past(accept));
endmodule

// File: tb/sim_pfvm_insn_decoder.sv
module sim_pfvm_insn_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  typedef struct packed {
    logic [63:0] w0;
    logic [63:0] w1;
    logic        wide;
    logic [63:0] imm;
    logic        err;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{ {32'h0, 16'h0, 4'd2, 4'd1, 8'h0f}, 64'h0, 1'b0, 64'h0, 1'b0 },
    '{ {32'hFFFF_FFF6, 16'hFFFC, 4'd0, 4'd10, 8'h07}, 64'h0, 1'b0, 64'hFFFF_FFFF_FFFF_FFF6, 1'b0 },
    '{ {32'h7FFF_FFFF, 16'h0010, 4'd0, 4'd3, 8'hb4}, 64'h0, 1'b0, 64'h0000_0000_7FFF_FFFF, 1'b0 },
    '{ {32'h5, 16'h0, 4'd0, 4'd11, 8'h07}, 64'h0, 1'b0, 64'h5, 1'b1 },
    '{ {32'h0, 16'h0002, 4'd12, 4'd0, 8'h5d}, 64'h0, 1'b0, 64'h0, 1'b1 },
    '{ {32'h89AB_CDEF, 16'h0, 4'd0, 4'd4, 8'h18}, {32'h0123_4567, 32'h0}, 1'b1, 64'h0123_4567_89AB_CDEF, 1'b0 },
    '{ {32'hFFFF_FFFF, 16'h0, 4'd15, 4'd0, 8'h18}, {32'h8000_0000, 32'h0}, 1'b1, 64'h8000_0000_FFFF_FFFF, 1'b0 },
    '{ {32'h5, 16'h0, 4'd0, 4'd2, 8'h18}, {32'h1, 16'h0001, 16'h0}, 1'b1, 64'h0000_0001_0000_0005, 1'b1 },
    '{ {32'h0, 16'h0, 4'd0, 4'd2, 8'h18}, {32'h0, 24'h0, 8'h18}, 1'b1, 64'h0, 1'b1 },
    '{ {32'h7, 16'h0, 4'd0, 4'd11, 8'h18}, {32'h0, 32'h0}, 1'b1, 64'h7, 1'b1 }
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [2:0]  out_cls;
  logic        out_srcsel;
  logic [3:0]  out_op, out_dst, out_src;
  logic [15:0] out_off;
  logic [63:0] out_imm;
  logic        out_wide, out_err;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfvm_insn_decoder u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_cls(out_cls), .out_srcsel(out_srcsel), .out_op(out_op),
    .out_dst(out_dst), .out_src(out_src), .out_off(out_off),
    .out_imm(out_imm), .out_wide(out_wide), .out_err(out_err)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fields_of(input logic [63:0] w);
    return {w[2:0], w[3], w[7:4], w[11:8], w[15:12], w[31:16]};
  endfunction

  task automatic put(input logic [63:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", {63'h0, out_valid}, 64'h0);
    check("R1 in_ready in reset", {63'h0, in_ready}, 64'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", {63'h0, out_valid}, 64'h0);
    out_ready = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      put(VECS[i].w0);
      if (VECS[i].wide) begin
        check("R4 no output after first wide word", {63'h0, out_valid}, 64'h0);
        put(VECS[i].w1);
      end
      check("R3/R4 out_valid", {63'h0, out_valid}, 64'h1);
      check("R2 fields", {32'h0, fields_of({out_imm[31:0], out_off, out_src, out_dst,
             out_op, out_srcsel, out_cls})}, {32'h0, fields_of(VECS[i].w0)});
      check(VECS[i].wide ? "R4 joined imm" : "R3 sign-extended imm", out_imm, VECS[i].imm);
      check("R4 wide flag", {63'h0, out_wide}, {63'h0, VECS[i].wide});
      check("R5/R6 error flag", {63'h0, out_err}, {63'h0, VECS[i].err});
    end

    // R7: stall holds output and blocks input
    @(negedge clk);
    out_ready = 1'b0;
    put({32'hDEAD_0001, 16'h0, 4'd1, 4'd2, 8'h0c});
    in_valid = 1'b1;
    in_word  = {32'h0000_0002, 16'h0, 4'd3, 4'd4, 8'h04};
    @(negedge clk);
    @(negedge clk);
    check("R7 in_ready low while stalled", {63'h0, in_ready}, 64'h0);
    check("R7 out_valid held", {63'h0, out_valid}, 64'h1);
    check("R7 imm held", out_imm, 64'hFFFF_FFFF_DEAD_0001);
    check("R7 dst held", {60'h0, out_dst}, 64'h2);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 next word after release", out_imm, 64'h2);
    check("R7 next dst after release", {60'h0, out_dst}, 64'h4);
    @(negedge clk);
    check("R1 out_valid drops when drained", {63'h0, out_valid}, 64'h0);
    check("R1 in_ready idle", {63'h0, in_ready}, 64'h1);

    finish_run();
  end
endmodule